// File: doc/BRIEF.md
# Serial-Link Power-Mode Sequencer

This block decides which power mode a byte-level serial network link controller is in, and drives the signals that follow from that mode. It tracks four modes: reset, run, wait and stop.

The block leaves reset mode once the reset-source flag drops. From run mode, a CPU wait or stop instruction strobe moves it into a low-power mode. A configuration bit decides whether a wait instruction gives the clocks-running wait mode or the clocks-stopped stop mode. In the low-power modes the block watches for a wake-up event:
- In wait mode, a passive-to-active edge on the bus or an end-of-frame pulse wakes it.
- In stop mode, only a bus edge wakes it.

A wake-up raises a sticky CPU interrupt request and returns the block to run mode.

The link core uses the clock-enable output to gate its own clocks. The physical interface uses the low-power request to drop into its idle state. The CPU reads the interrupt request and clears it with a one-cycle strobe. The receive line is asynchronous and passes through a two-stage synchronizer inside the block.

Top module: `linkpm_seq`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 00 (reset), `clk_en_o` is 1, `lp_req_o` is 0 and `wake_irq_o` is 0. A high `src_reset_i` at a clock edge puts `mode_o` at 00 and clears `wake_irq_o` after that edge, from any mode.
- R2: In reset mode, the first clock edge with `src_reset_i` low moves `mode_o` to 01 (run). While `src_reset_i` stays high, the mode stays 00.
- R3: In run mode, a `cpu_wait_i` strobe with `wait_to_stop_i` = 0 and `cpu_stop_i` = 0 moves `mode_o` to 10 (wait) at the next edge.
- R4: In run mode, a `cpu_stop_i` strobe, or a `cpu_wait_i` strobe with `wait_to_stop_i` = 1, moves `mode_o` to 11 (stop) at the next edge. Stop wins when both strobes are high.
- R5: In wait mode, `clk_en_o` = 1 and `lp_req_o` = 0.
- R6: In stop mode, `clk_en_o` = 0 and `lp_req_o` = 1.
- R7: In wait or stop mode, a 0-to-1 change of `rx_level_i` (0 is the passive level) moves `mode_o` to 01 and sets `wake_irq_o` at the third clock edge after the change. The change must come at least one cycle after the mode was entered.
- R8: An `eof_i` pulse in wait mode moves `mode_o` to 01 and sets `wake_irq_o` at the next edge. In stop mode `eof_i` has no effect.
- R9: A receive level that is already 1 when a low-power mode is entered does not wake the block. A wake needs a later 0 followed by a 1.
- R10: `wake_irq_o` stays set until an `irq_clr_i` strobe clears it at the next edge. A wake and a clear in the same cycle leave it set.
- R11: In run mode, `eof_i` pulses and `rx_level_i` edges leave `mode_o` at 01 and leave `wake_irq_o` unchanged.
- R12: In wait or stop mode, the `cpu_wait_i` and `cpu_stop_i` strobes leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_reset_i | input | 1 | High while any reset source of the link is active |
| cpu_wait_i | input | 1 | One-cycle strobe: CPU executed a wait instruction |
| cpu_stop_i | input | 1 | One-cycle strobe: CPU executed a stop instruction |
| wait_to_stop_i | input | 1 | 1: a wait instruction selects stop mode; 0: it selects wait mode |
| rx_level_i | input | 1 | Asynchronous filtered receive-line level, 0 = passive |
| eof_i | input | 1 | One-cycle pulse: a valid end-of-frame was detected |
| irq_clr_i | input | 1 | One-cycle strobe from the CPU that clears the interrupt |
| clk_en_o | output | 1 | Clock enable for the link core |
| lp_req_o | output | 1 | Low-power request to the physical interface |
| wake_irq_o | output | 1 | Sticky CPU wake interrupt request |
| mode_o | output | 2 | Current mode: 00 reset, 01 run, 10 wait, 11 stop |

## Verification
Mode changes caused by the CPU strobes, by `eof_i` and by `src_reset_i` appear one edge after the strobe. A receive-line edge takes three edges to show: two synchronizer stages plus the mode register. Clearing the interrupt takes one edge.

The bench drives every input on the falling clock edge and counts falling edges to place each check. For a bus wake it samples once after the second rising edge, where the old mode must still hold, and once after the third, where the wake must have landed. A sweep over the configuration bit, the three instruction-strobe combinations and the two wake sources checks each expected mode arithmetically from the strobe bits.

// File: rtl/linkpm_pkg.sv
package linkpm_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LPM_RESET = 2'b00,
    LPM_RUN   = 2'b01,
    LPM_WAIT  = 2'b10,
    LPM_STOP  = 2'b11
  } lpm_mode_e;

  // Both low-power modes share the upper code bit.
  function automatic logic is_low_power(input lpm_mode_e m);
    return m[MODE_W-1];
  endfunction

endpackage

// File: rtl/linkpm_sync.sv
// Multi-stage synchronizer with asynchronous clear to a chosen value.
module linkpm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RESET_VAL;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RESET_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/linkpm_wake_det.sv
// Detects a passive-to-active (0->1) change of the synchronized receive
// level, counted only once the detector has been armed by a full cycle
// of low-power mode.
module linkpm_wake_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_s_i,
  input  logic low_power_i,
  output logic rise_o
);

  logic armed_q, armed_d, armed_en;
  logic prev_q;

  always_comb begin
    armed_d  = low_power_i;
    armed_en = (armed_d != armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_s_i;
  end

  assign rise_o = armed_q & low_power_i & level_s_i & ~prev_q;

endmodule

// File: rtl/linkpm_mode_fsm.sv
module linkpm_mode_fsm
  import linkpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src_reset_i,
  input  logic      cpu_wait_i,
  input  logic      cpu_stop_i,
  input  logic      wait_to_stop_i,
  input  logic      bus_rise_i,
  input  logic      eof_i,
  output lpm_mode_e mode_o,
  output logic      wake_o
);

  lpm_mode_e mode_q, mode_d;
  logic      mode_en;

  // Next-state process.
  always_comb begin
    mode_d = mode_q;
    wake_o = 1'b0;
    if (src_reset_i) begin
      mode_d = LPM_RESET;
    end else begin
      unique case (mode_q)
        LPM_RESET: mode_d = LPM_RUN;
        LPM_RUN: begin
          if (cpu_stop_i || (cpu_wait_i && wait_to_stop_i)) begin
            mode_d = LPM_STOP;
          end else if (cpu_wait_i) begin
            mode_d = LPM_WAIT;
          end
        end
        LPM_WAIT: begin
          if (bus_rise_i || eof_i) begin
            mode_d = LPM_RUN;
            wake_o = 1'b1;
          end
        end
        LPM_STOP: begin
          if (bus_rise_i) begin
            mode_d = LPM_RUN;
            wake_o = 1'b1;
          end
        end
        default: mode_d = LPM_RESET;
      endcase
    end
    mode_en = (mode_d != mode_q);
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LPM_RESET;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/linkpm_irq.sv
// Sticky wake interrupt: a set wins over a clear, a flush wins over both.
module linkpm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic irq_o
);

  logic irq_q, irq_d, irq_en;

  always_comb begin
    if (flush_i)      irq_d = 1'b0;
    else if (set_i)   irq_d = 1'b1;
    else if (clr_i)   irq_d = 1'b0;
    else              irq_d = irq_q;
    irq_en = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/linkpm_seq.sv
module linkpm_seq
  import linkpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_reset_i,
  input  logic              cpu_wait_i,
  input  logic              cpu_stop_i,
  input  logic              wait_to_stop_i,
  input  logic              rx_level_i,
  input  logic              eof_i,
  input  logic              irq_clr_i,
  output logic              clk_en_o,
  output logic              lp_req_o,
  output logic              wake_irq_o,
  output logic [MODE_W-1:0] mode_o
);

  logic      rst_sync_n;
  logic      rx_s;
  logic      bus_rise;
  logic      wake;
  lpm_mode_e mode;

  // Reset: asserted asynchronously, released on the clock.
  linkpm_sync #(.STAGES(RST_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  linkpm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (rx_level_i),
    .q_o   (rx_s)
  );

  linkpm_wake_det u_wake_det (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .level_s_i   (rx_s),
    .low_power_i (is_low_power(mode)),
    .rise_o      (bus_rise)
  );

  linkpm_mode_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .src_reset_i    (src_reset_i),
    .cpu_wait_i     (cpu_wait_i),
    .cpu_stop_i     (cpu_stop_i),
    .wait_to_stop_i (wait_to_stop_i),
    .bus_rise_i     (bus_rise),
    .eof_i          (eof_i),
    .mode_o         (mode),
    .wake_o         (wake)
  );

  linkpm_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (wake),
    .clr_i   (irq_clr_i),
    .flush_i (src_reset_i),
    .irq_o   (wake_irq_o)
  );

  assign clk_en_o = (mode != LPM_STOP);
  assign lp_req_o = (mode == LPM_STOP);
  assign mode_o   = mode;

endmodule

// File: rtl/linkpm_seq_chk.sv
module linkpm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       src_reset_i,
  input logic       cpu_wait_i,
  input logic       cpu_stop_i,
  input logic       wait_to_stop_i,
  input logic       eof_i,
  input logic       irq_clr_i,
  input logic       clk_en_o,
  input logic       lp_req_o,
  input logic       wake_irq_o,
  input logic [1:0] mode_o
);

  a_r1_src_reset_forces: assert property (@(posedge clk) disable iff (!rst_n)
    src_reset_i |=> (mode_o == 2'b00) && !wake_irq_o);

  a_r3_wait_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) && cpu_wait_i && !cpu_stop_i && !wait_to_stop_i && !src_reset_i
      |=> mode_o == 2'b10);

  a_r4_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) && (cpu_stop_i || (cpu_wait_i && wait_to_stop_i)) && !src_reset_i
      |=> mode_o == 2'b11);

  a_r5_wait_clocks_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> clk_en_o && !lp_req_o);

  a_r6_stop_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> !clk_en_o && lp_req_o);

  a_r8_eof_wakes_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) && eof_i && !src_reset_i |=> (mode_o == 2'b01) && wake_irq_o);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o && !irq_clr_i && !src_reset_i |=> wake_irq_o);

  a_r11_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) && !cpu_wait_i && !cpu_stop_i && !src_reset_i |=> mode_o == 2'b01);

endmodule

bind linkpm_seq linkpm_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .src_reset_i    (src_reset_i),
  .cpu_wait_i     (cpu_wait_i),
  .cpu_stop_i     (cpu_stop_i),
  .wait_to_stop_i (wait_to_stop_i),
  .eof_i          (eof_i),
  .irq_clr_i      (irq_clr_i),
  .clk_en_o       (clk_en_o),
  .lp_req_o       (lp_req_o),
  .wake_irq_o     (wake_irq_o),
  .mode_o         (mode_o)
);

// File: tb/linkpm_seq_bench.sv
`timescale 1ns/1ps
module linkpm_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, src_reset, cpu_wait, cpu_stop, w2s, rx, eof, clr;
  logic clk_en, lp_req, irq;
  logic [1:0] mode;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linkpm_seq u_linkpm_seq (
    .clk(clk), .rst_n(rst_n), .src_reset_i(src_reset), .cpu_wait_i(cpu_wait),
    .cpu_stop_i(cpu_stop), .wait_to_stop_i(w2s), .rx_level_i(rx), .eof_i(eof),
    .irq_clr_i(clr), .clk_en_o(clk_en), .lp_req_o(lp_req), .wake_irq_o(irq),
    .mode_o(mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One-cycle strobes, driven and released on falling edges.
  task automatic pulse_wait();  cpu_wait = 1; step(1); cpu_wait = 0; endtask
  task automatic pulse_stop();  cpu_stop = 1; step(1); cpu_stop = 0; endtask
  task automatic pulse_eof();   eof = 1;      step(1); eof = 0;      endtask
  task automatic pulse_clr();   clr = 1;      step(1); clr = 0;      endtask

  initial begin
    rst_n = 0; src_reset = 1; cpu_wait = 0; cpu_stop = 0; w2s = 0;
    rx = 0; eof = 0; clr = 0;
    step(3);
    check("R1 reset mode", mode, 0);
    check("R1 reset clk_en", clk_en, 1);
    check("R1 reset lp_req", lp_req, 0);
    check("R1 reset irq", irq, 0);
    rst_n = 1;
    step(4);
    check("R2 held in reset by source", mode, 0);
    src_reset = 0;
    step(1);
    check("R2 run after source released", mode, 1);

    // R11: run ignores end-of-frame and bus edges.
    pulse_eof();
    rx = 1; step(4); rx = 0; step(4);
    check("R11 run mode kept", mode, 1);
    check("R11 irq untouched", irq, 0);

    // Sweep: config bit x instruction strobes x wake source.
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int ins = 1; ins < 4; ins++) begin
        for (int src = 0; src < 2; src++) begin
          int exp_stop;
          int exp_mode;
          exp_stop = ((ins >> 1) & 1) | ((ins & 1) & cfg);
          exp_mode = exp_stop ? 3 : 2;
          w2s = cfg[0];
          cpu_wait = ins[0]; cpu_stop = ins[1];
          step(1);
          cpu_wait = 0; cpu_stop = 0;
          check(exp_stop ? "R4 stop entry" : "R3 wait entry", mode, exp_mode);
          check(exp_stop ? "R6 stop clk_en" : "R5 wait clk_en", clk_en, exp_stop ? 0 : 1);
          check(exp_stop ? "R6 stop lp_req" : "R5 wait lp_req", lp_req, exp_stop);
          cpu_wait = 1; cpu_stop = 1; step(1); cpu_wait = 0; cpu_stop = 0;
          check("R12 strobes ignored in low power", mode, exp_mode);
          step(1);
          if (src == 1) begin
            pulse_eof();
            if (exp_stop == 0) begin
              check("R8 eof wakes wait", mode, 1);
              check("R8 eof sets irq", irq, 1);
            end else begin
              check("R8 eof ignored in stop", mode, 3);
              check("R8 eof no irq in stop", irq, 0);
            end
          end
          if (mode != 2'd1) begin
            rx = 1;
            step(2);
            check("R7 no wake before sync latency", mode, exp_mode);
            step(1);
            check("R7 bus edge wakes", mode, 1);
            check("R7 bus edge sets irq", irq, 1);
          end
          step(2);
          check("R10 irq sticky", irq, 1);
          pulse_clr();
          check("R10 irq cleared", irq, 0);
          rx = 0;
          step(3);
        end
      end
    end

    // R9: level already active at entry does not wake.
    w2s = 0; rx = 1; step(3);
    pulse_wait();
    step(5);
    check("R9 high level at entry no wake", mode, 2);
    rx = 0; step(3); rx = 1; step(3);
    check("R9 later 0-1 wakes", mode, 1);
    pulse_clr(); rx = 0; step(3);

    // R10: wake and clear in the same cycle leave irq set.
    pulse_wait();
    eof = 1; clr = 1; step(1); eof = 0; clr = 0;
    check("R10 set wins over clear", irq, 1);

    // R1: reset source in wait clears irq and forces reset mode.
    pulse_wait();
    check("R1 back in wait", mode, 2);
    src_reset = 1; step(1);
    check("R1 source forces reset mode", mode, 0);
    check("R1 source clears irq", irq, 0);
    check("R1 clk_en on in reset", clk_en, 1);
    src_reset = 0; step(1);
    check("R2 run after reset again", mode, 1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule